// File: doc/BRIEF.md
# Reset Pin Pulse Classifier

This block watches an active-low external reset pin and decides whether each low pulse is a genuine reset request or a disturbance. The pin level passes through a two-flop synchronizer, then a saturating counter measures how many consecutive cycles it stays asserted. A pulse of two cycles or fewer is dropped without trace. A pulse that lasts past two cycles but ends before the tenth sets a sticky glitch flag. A pulse that reaches ten cycles is accepted as a real reset request: the block emits a single-cycle accept pulse and clears the glitch flag.

The flag is one bit of a wider reset status register. It is cleared by a write-one-to-clear strobe from software or by an accepted long pulse. While the system reports that a reset cycle is already in progress, the pin is ignored. An assertion that overlaps such a busy window is discarded until the pin is seen released.

Top module: `rstGlitchDet`

## Requirements
- R1: After system reset the glitch flag output and the accept output are both 0.
- R2: A pin assertion lasting 1 or 2 synchronized cycles leaves the glitch flag unchanged, whether it was 0 or 1, and produces no accept pulse.
- R3: A pin assertion lasting 3 to 9 synchronized cycles sets the glitch flag to 1 once the release is seen, and produces no accept pulse.
- R4: Once set, the glitch flag stays 1 through further pulses of 1 to 9 cycles until it is cleared.
- R5: A one-cycle high pulse on the clear strobe sets the glitch flag to 0.
- R6: A pin assertion that reaches 10 synchronized cycles produces exactly one accept pulse, one cycle wide, and the glitch flag is 0 from that cycle on.
- R7: Holding the pin asserted well beyond 10 cycles produces no second accept pulse until the pin is released and asserted again.
- R8: Pin assertions that begin while the busy input is 1, or that are still under way when it becomes 1, neither set the flag nor produce an accept pulse, even if the pin stays low after busy falls.
- R9: When a clear strobe and a middle-length release fall in the same cycle, the glitch flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low system reset |
| pinRawN | input | 1 | External reset pin level, active low, asynchronous |
| resetBusy | input | 1 | High while a reset cycle is already being processed |
| flagClr | input | 1 | Write-one-to-clear strobe for the glitch flag |
| glitchFlag | output | 1 | Sticky glitch status bit |
| pinResetAccepted | output | 1 | One-cycle pulse when a long pin assertion is accepted |

## Verification
A stuck or mis-sequenced classifier state shows at the ports as a wrong flag value a few cycles after the pin is released, or as a missing, doubled or widened accept pulse. Because the pin passes through two synchronizer stages before the counter, each outcome appears three clock edges after the pin edge that decides it, so the bench samples well after that. The same-cycle clear test aims the strobe at the exact edge on which the release is classified, which exposes any wrong priority directly.

// File: rtl/rstGlitchPkg.sv
package rstGlitchPkg;

  typedef enum logic [1:0] {
    GD_IDLE  = 2'd0,
    GD_COUNT = 2'd1,
    GD_ARMED = 2'd2,
    GD_HELD  = 2'd3
  } gdState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic setFlag;
    logic longClr;
    logic accept;
  } gdStrobe_t;

  // counter status from datapath to control
  typedef struct packed {
    logic armReach;
    logic longReach;
  } gdStatus_t;

endpackage

// File: rtl/rstGlitchSync.sv
module rstGlitchSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic dIn,
  output logic dOut
);

  logic [STAGES-1:0] stage;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[0] <= 1'b1;
          else       stage[0] <= dIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[i] <= 1'b1;
          else       stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign dOut = stage[STAGES-1];

endmodule

// File: rtl/rstGlitchData.sv
module rstGlitchData
  import rstGlitchPkg::*;
#(
  parameter int SHORT_LIMIT = 2,
  parameter int LONG_LIMIT  = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      pinRawN,
  input  logic      flagClr,
  input  gdStrobe_t strb,
  output logic      pinAsserted,
  output gdStatus_t stat,
  output logic      glitchFlag,
  output logic      accept
);

  localparam int CNT_W = $clog2(LONG_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(LONG_LIMIT);
  localparam logic [CNT_W-1:0] ARM_AT   = CNT_W'(SHORT_LIMIT);
  localparam logic [CNT_W-1:0] LONG_PRE = CNT_W'(LONG_LIMIT - 1);

  logic pinSyncN;
  logic [CNT_W-1:0] holdCnt;

  rstGlitchSync #(.STAGES(SYNC_STAGES)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .dIn  (pinRawN),
    .dOut (pinSyncN)
  );

  assign pinAsserted = ~pinSyncN;

  // saturating count of consecutive asserted cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               holdCnt <= '0;
    else if (strb.cntClr)                    holdCnt <= '0;
    else if (strb.cntInc && holdCnt != CNT_MAX) holdCnt <= holdCnt + 1'b1;
  end

  // the current edge would be the (SHORT_LIMIT+1)th / LONG_LIMITth asserted cycle
  assign stat.armReach  = (holdCnt >= ARM_AT);
  assign stat.longReach = (holdCnt == LONG_PRE);

  // sticky flag: detection has priority over any clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          glitchFlag <= 1'b0;
    else if (strb.setFlag)              glitchFlag <= 1'b1;
    else if (flagClr || strb.longClr)   glitchFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) accept <= 1'b0;
    else       accept <= strb.accept;
  end

endmodule

// File: rtl/rstGlitchCtrl.sv
module rstGlitchCtrl
  import rstGlitchPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      pinAsserted,
  input  logic      resetBusy,
  input  gdStatus_t stat,
  output gdStrobe_t strb
);

  gdState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= GD_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      GD_IDLE: begin
        if (pinAsserted && resetBusy) begin
          strb.cntClr = 1'b1;
          stateNext   = GD_HELD;
        end else if (pinAsserted) begin
          strb.cntInc = 1'b1;
          stateNext   = GD_COUNT;
        end else begin
          strb.cntClr = 1'b1;
        end
      end
      GD_COUNT: begin
        if (resetBusy || !pinAsserted) begin
          strb.cntClr = 1'b1;
          stateNext   = pinAsserted ? GD_HELD : GD_IDLE;
        end else begin
          strb.cntInc = 1'b1;
          if (stat.armReach) stateNext = GD_ARMED;
        end
      end
      GD_ARMED: begin
        if (resetBusy) begin
          strb.cntClr = 1'b1;
          stateNext   = pinAsserted ? GD_HELD : GD_IDLE;
        end else if (!pinAsserted) begin
          strb.cntClr  = 1'b1;
          strb.setFlag = 1'b1;
          stateNext    = GD_IDLE;
        end else if (stat.longReach) begin
          strb.cntInc  = 1'b1;
          strb.accept  = 1'b1;
          strb.longClr = 1'b1;
          stateNext    = GD_HELD;
        end else begin
          strb.cntInc = 1'b1;
        end
      end
      GD_HELD: begin
        if (!pinAsserted) begin
          strb.cntClr = 1'b1;
          stateNext   = GD_IDLE;
        end else begin
          strb.cntInc = 1'b1;
        end
      end
      default: stateNext = GD_IDLE;
    endcase
  end

endmodule

// File: rtl/rstGlitchDet.sv
module rstGlitchDet
  import rstGlitchPkg::*;
#(
  parameter int SHORT_LIMIT = 2,
  parameter int LONG_LIMIT  = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinRawN,
  input  logic resetBusy,
  input  logic flagClr,
  output logic glitchFlag,
  output logic pinResetAccepted
);

  gdStrobe_t strb;
  gdStatus_t stat;
  logic      pinAsserted;

  rstGlitchData #(
    .SHORT_LIMIT (SHORT_LIMIT),
    .LONG_LIMIT  (LONG_LIMIT),
    .SYNC_STAGES (SYNC_STAGES)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .pinRawN     (pinRawN),
    .flagClr     (flagClr),
    .strb        (strb),
    .pinAsserted (pinAsserted),
    .stat        (stat),
    .glitchFlag  (glitchFlag),
    .accept      (pinResetAccepted)
  );

  rstGlitchCtrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .pinAsserted (pinAsserted),
    .resetBusy   (resetBusy),
    .stat        (stat),
    .strb        (strb)
  );

endmodule

// File: rtl/rstGlitchDetChk.sv
module rstGlitchDetChk (
  input logic clk,
  input logic rstN,
  input logic pinAsserted,
  input logic resetBusy,
  input logic flagClr,
  input logic glitchFlag,
  input logic accept
);

  // R6
  accept_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !accept);

  // R6
  accept_clears_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> !glitchFlag);

  // R3
  flag_after_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(glitchFlag) |-> !$past(pinAsserted));

  // R8
  busy_blocks_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetBusy |=> !accept);

  // R5
  sw_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && pinAsserted) |=> !glitchFlag);

  // R7
  accept_while_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> $past(pinAsserted));

endmodule

bind rstGlitchDet rstGlitchDetChk uChk (
  .clk         (clk),
  .rstN        (rstN),
  .pinAsserted (pinAsserted),
  .resetBusy   (resetBusy),
  .flagClr     (flagClr),
  .glitchFlag  (glitchFlag),
  .accept      (pinResetAccepted)
);

// File: tb/rstGlitchDet_test.sv
`timescale 1ns/1ps
module rstGlitchDet_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pinRawN = 1'b1;
  logic resetBusy = 1'b0;
  logic flagClr = 1'b0;
  logic glitchFlag;
  logic pinResetAccepted;

  always #2.5 clk = ~clk;

  rstGlitchDet uut (
    .clk              (clk),
    .rstN             (rstN),
    .pinRawN          (pinRawN),
    .resetBusy        (resetBusy),
    .flagClr          (flagClr),
    .glitchFlag       (glitchFlag),
    .pinResetAccepted (pinResetAccepted)
  );

  typedef struct {
    string req;
    logic  expFlag;
    int    expPulses;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int fails = 0;
  int acceptCycles = 0;
  bit finished = 0;

  // monitor: counts accept cycles, compares against expected items
  always @(negedge clk) begin
    if (pinResetAccepted) acceptCycles++;
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      checks++;
      if (glitchFlag !== it.expFlag || acceptCycles != it.expPulses) begin
        fails++;
        $display("FAIL %s: flag=%0b pulses=%0d expected flag=%0b pulses=%0d",
                 it.req, glitchFlag, acceptCycles, it.expFlag, it.expPulses);
      end
      acceptCycles = 0;
    end
  end

  task automatic expect_state(string req, logic f, int p);
    expItem_t it;
    it.req = req; it.expFlag = f; it.expPulses = p;
    expQ.push_back(it);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pinPulse(int n);
    @(negedge clk);
    pinRawN = 1'b0;
    repeat (n) @(negedge clk);
    pinRawN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expect_state("R1", 1'b0, 0);

    pinPulse(2);  expect_state("R2", 1'b0, 0);
    pinPulse(1);  expect_state("R2", 1'b0, 0);
    pinPulse(3);  expect_state("R3", 1'b1, 0);
    pinPulse(2);  expect_state("R2", 1'b1, 0);
    pinPulse(7);  expect_state("R4", 1'b1, 0);

    @(negedge clk); flagClr = 1'b1;
    @(negedge clk); flagClr = 1'b0;
    repeat (3) @(negedge clk);
    expect_state("R5", 1'b0, 0);

    pinPulse(9);  expect_state("R3", 1'b1, 0);
    pinPulse(10); expect_state("R6", 1'b0, 1);
    pinPulse(40); expect_state("R7", 1'b0, 1);
    pinPulse(4);  expect_state("R3", 1'b1, 0);
    pinPulse(25); expect_state("R7", 1'b0, 1);

    // busy from the start of the pulses
    resetBusy = 1'b1;
    pinPulse(5);
    pinPulse(15);
    resetBusy = 1'b0;
    repeat (2) @(negedge clk);
    expect_state("R8", 1'b0, 0);

    // busy arriving mid-pulse, pin stays low afterwards
    @(negedge clk); pinRawN = 1'b0;
    repeat (4) @(negedge clk); resetBusy = 1'b1;
    repeat (3) @(negedge clk); resetBusy = 1'b0;
    repeat (13) @(negedge clk); pinRawN = 1'b1;
    repeat (6) @(negedge clk);
    expect_state("R8", 1'b0, 0);

    // clear strobe on the exact classification edge
    @(negedge clk); pinRawN = 1'b0;
    repeat (4) @(negedge clk); pinRawN = 1'b1;
    repeat (2) @(negedge clk); flagClr = 1'b1;
    @(negedge clk); flagClr = 1'b0;
    repeat (4) @(negedge clk);
    expect_state("R9", 1'b1, 0);

    pinPulse(10); expect_state("R6", 1'b0, 1);

    wait (expQ.size() == 0);
    @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule